// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Decoder

This block decides, for every memory access into the top 256 KB of the first megabyte, whether the read or the write should be served from internal DRAM or sent out to the external bus. Two configuration bytes control it. The first byte holds one enable bit per 16 KB segment of the option-ROM window (0xC0000 to 0xDFFFF). The second byte holds one enable bit per 32 KB segment of the BIOS window (0xE0000 to 0xFFFFF). It also holds two attribute bits, one for reads and one for writes, which every enabled segment in both windows shares.

The configuration bytes are latched inside the block. A write to either byte takes effect only while the configuration space is unlocked. The decode of a presented address is registered, so the routing flags appear one clock after the address. The block also reports whether the BIOS area is shadowed for reads and for writes, and it flags addresses that fall below the decoded window.

Top module: `shadow_attr_decoder`

## Requirements
- R1: While `rst` is high on a clock edge, both latched control bytes clear to 0x00 and every output register clears to 0. At the first decode after reset, every in-window address routes externally.
- R2: An address with bits [19:17] = 3'b110 lies in the low window. Its segment index is address bits [16:14], and that segment is enabled when the matching bit of the low control byte (`cfg_sel` = 0) is set.
- R3: An address with bits [19:17] = 3'b111 lies in the high window. Its segment index is address bits [16:15], and that segment is enabled when the matching bit [3:0] of the high control byte (`cfg_sel` = 1) is set. The low control byte has no effect on this window.
- R4: For an enabled segment, `rd_int_o` equals bit 4 of the high control byte and `wr_int_o` equals bit 5 of it.
- R5: For a disabled segment, `rd_int_o` and `wr_int_o` are both 0, whatever the attribute bits are.
- R6: `bios_rd_shadow_o` and `bios_wr_shadow_o` show bits 4 and 5 of the latched high control byte. They change on the clock edge that latches a new value.
- R7: A control write (`cfg_we` high) with `cfg_unlock` low leaves both latched bytes unchanged.
- R8: An address with bits [19:18] other than 2'b11 sets `out_of_range_o` and forces both internal flags to 0. An in-window address clears `out_of_range_o`.
- R9: `acc_int_o` is 1 only when `mem_valid` was high and the access type was served internally: `wr_int_o` for `mem_write` = 1, and `rd_int_o` for `mem_write` = 0.
- R10: The decode outputs reflect the address sampled on the previous edge. They use the control bytes as they stood before that edge, so a control write on the same edge affects the following decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_unlock | input | 1 | Configuration space unlocked |
| cfg_sel | input | 1 | 0 selects the low-window enable byte, 1 selects the high-window byte |
| cfg_wdata | input | 8 | Control byte write data |
| mem_addr | input | 20 | Access address |
| mem_valid | input | 1 | Access qualifier |
| mem_write | input | 1 | 1 = write access, 0 = read access |
| rd_int_o | output | 1 | Reads of the addressed segment go to internal DRAM |
| wr_int_o | output | 1 | Writes of the addressed segment go to internal DRAM |
| acc_int_o | output | 1 | The qualified access is served internally |
| out_of_range_o | output | 1 | Address below the decoded window |
| bios_rd_shadow_o | output | 1 | BIOS area shadowed for reads |
| bios_wr_shadow_o | output | 1 | BIOS area shadowed for writes |

## Verification
A corrupted latched byte shows up in the shadow status pins on the very next edge. It also shows up in the routing flags of the first access to an affected segment, one cycle after the address. A wrong segment index appears only when an address lands in a segment whose enable bit differs from its neighbour's. The stimulus therefore sets isolated enable bits and probes both the enabled segment and the segment next to it, at segment edges in each window. Lock handling and the one-cycle ordering between a control write and a decode are probed by placing the two on adjacent edges and on the same edge.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int ADDR_W      = 20;
  localparam int CTL_W       = 8;
  localparam int LO_SEGS     = 8;
  localparam int HI_SEGS     = 4;
  localparam int LO_SHIFT    = 14;
  localparam int HI_SHIFT    = 15;
  localparam int RD_ATTR_BIT = 4;
  localparam int WR_ATTR_BIT = 5;
  localparam int TAG_W       = 3;
  localparam logic [TAG_W-1:0] LO_TAG = 3'b110;
  localparam logic [TAG_W-1:0] HI_TAG = 3'b111;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LO   = 2'd1,
    WIN_HI   = 2'd2
  } window_e;
endpackage

// File: rtl/shadow_ctl_regs.sv
module shadow_ctl_regs #(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_unlock,
  input  logic             cfg_sel,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic [CTL_W-1:0] ctl_lo,
  output logic [CTL_W-1:0] ctl_hi
);
  logic wr_ok;
  assign wr_ok = cfg_we && cfg_unlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_lo <= '0;
      ctl_hi <= '0;
    end else if (wr_ok) begin
      if (cfg_sel) ctl_hi <= cfg_wdata;
      else         ctl_lo <= cfg_wdata;
    end
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_unlock) |=> ($stable(ctl_lo) && $stable(ctl_hi))); // R7
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_unlock && cfg_sel) |=> (ctl_hi == $past(cfg_wdata))); // R6
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_unlock && !cfg_sel) |=> (ctl_lo == $past(cfg_wdata))); // R2
endmodule

// File: rtl/shadow_window_cls.sv
module shadow_window_cls
  import shadow_attr_pkg::*;
#(
  parameter int AW = 20,
  parameter int TW = 3
) (
  input  logic [AW-1:0] addr,
  output window_e       win
);
  logic [TW-1:0] tag;
  assign tag = addr[AW-1 -: TW];

  always_comb begin
    if (tag == LO_TAG)      win = WIN_LO;
    else if (tag == HI_TAG) win = WIN_HI;
    else                    win = WIN_NONE;
  end
endmodule

// File: rtl/shadow_seg_match.sv
module shadow_seg_match #(
  parameter int AW    = 20,
  parameter int SEGS  = 8,
  parameter int SHIFT = 14,
  parameter int CTL_W = 8
) (
  input  logic [AW-1:0]    addr,
  input  logic [CTL_W-1:0] en_byte,
  output logic             hit
);
  localparam int IDX_W = (SEGS > 1) ? $clog2(SEGS) : 1;

  logic [IDX_W-1:0] idx;
  logic [SEGS-1:0]  sel;

  assign idx = addr[SHIFT +: IDX_W];

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    assign sel[i] = (idx == IDX_W'(i)) && en_byte[i];
  end

  assign hit = |sel;
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_attr_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int CW       = CTL_W,
  parameter int N_LO     = LO_SEGS,
  parameter int N_HI     = HI_SEGS,
  parameter int LO_SH    = LO_SHIFT,
  parameter int HI_SH    = HI_SHIFT,
  parameter int RD_BIT   = RD_ATTR_BIT,
  parameter int WR_BIT   = WR_ATTR_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_unlock,
  input  logic          cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic          mem_write,
  output logic          rd_int_o,
  output logic          wr_int_o,
  output logic          acc_int_o,
  output logic          out_of_range_o,
  output logic          bios_rd_shadow_o,
  output logic          bios_wr_shadow_o
);
  logic [CW-1:0] ctl_lo, ctl_hi;
  window_e       win;
  logic          lo_hit, hi_hit, seg_on;
  logic          rd_n, wr_n, oor_n, acc_n;

  shadow_ctl_regs #(.CTL_W(CW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_unlock(cfg_unlock),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctl_lo(ctl_lo), .ctl_hi(ctl_hi)
  );

  shadow_window_cls #(.AW(AW), .TW(TAG_W)) u_win (
    .addr(mem_addr), .win(win)
  );

  shadow_seg_match #(.AW(AW), .SEGS(N_LO), .SHIFT(LO_SH), .CTL_W(CW)) u_lo (
    .addr(mem_addr), .en_byte(ctl_lo), .hit(lo_hit)
  );

  shadow_seg_match #(.AW(AW), .SEGS(N_HI), .SHIFT(HI_SH), .CTL_W(CW)) u_hi (
    .addr(mem_addr), .en_byte(ctl_hi), .hit(hi_hit)
  );

  always_comb begin
    seg_on = ((win == WIN_LO) && lo_hit) || ((win == WIN_HI) && hi_hit);
    rd_n   = seg_on && ctl_hi[RD_BIT];
    wr_n   = seg_on && ctl_hi[WR_BIT];
    oor_n  = (win == WIN_NONE);
    acc_n  = mem_valid && (mem_write ? wr_n : rd_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_int_o       <= 1'b0;
      wr_int_o       <= 1'b0;
      acc_int_o      <= 1'b0;
      out_of_range_o <= 1'b0;
    end else begin
      rd_int_o       <= rd_n;
      wr_int_o       <= wr_n;
      acc_int_o      <= acc_n;
      out_of_range_o <= oor_n;
    end
  end

  assign bios_rd_shadow_o = ctl_hi[RD_BIT];
  assign bios_wr_shadow_o = ctl_hi[WR_BIT];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !(rd_int_o || wr_int_o || acc_int_o || bios_rd_shadow_o)); // R1
  AST_RD_NEEDS_ATTR: assert property (@(posedge clk) disable iff (rst)
    rd_int_o |-> $past(bios_rd_shadow_o)); // R4
  AST_WR_NEEDS_ATTR: assert property (@(posedge clk) disable iff (rst)
    wr_int_o |-> $past(bios_wr_shadow_o)); // R4
  AST_OOR_NO_INT: assert property (@(posedge clk) disable iff (rst)
    out_of_range_o |-> !(rd_int_o || wr_int_o)); // R8
  AST_ACC_QUAL: assert property (@(posedge clk) disable iff (rst)
    acc_int_o |-> (rd_int_o || wr_int_o)); // R9
  AST_ACC_VALID: assert property (@(posedge clk) disable iff (rst)
    acc_int_o |-> $past(mem_valid)); // R9
endmodule

// File: tb/shadow_attr_decoder_tb.sv
module shadow_attr_decoder_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_unlock = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [19:0] mem_addr = '0;
  logic mem_valid = 1'b0, mem_write = 1'b0;
  logic rd_int_o, wr_int_o, acc_int_o, out_of_range_o;
  logic bios_rd_shadow_o, bios_wr_shadow_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_attr_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_unlock(cfg_unlock),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_write(mem_write),
    .rd_int_o(rd_int_o), .wr_int_o(wr_int_o), .acc_int_o(acc_int_o),
    .out_of_range_o(out_of_range_o), .bios_rd_shadow_o(bios_rd_shadow_o),
    .bios_wr_shadow_o(bios_wr_shadow_o)
  );

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [19:0] addr;
    logic        wr;
    logic        e_rd;
    logic        e_wr;
    logic        e_oor;
    logic        e_acc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'h30, 20'hC0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'h01, 8'h30, 20'hC4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h80, 8'h10, 20'hDC000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h80, 8'h20, 20'hDFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h00, 8'h3F, 20'hE0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'h00, 8'h38, 20'hF8000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'h00, 8'h14, 20'hF7FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'hFF, 8'h30, 20'hE8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hFF, 8'h00, 20'hC8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hFF, 8'h3F, 20'hBFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'hFF, 8'h3F, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h02, 8'h30, 20'hC4000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d, input logic unl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_unlock = unl;
    @(negedge clk);
    cfg_we = 1'b0; cfg_unlock = 1'b0;
  endtask

  task automatic probe(input logic [19:0] a, input logic w);
    @(negedge clk);
    mem_addr = a; mem_valid = 1'b1; mem_write = w;
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rd in reset", rd_int_o, 1'b0);
    chk("R1", "oor in reset", out_of_range_o, 1'b0);
    chk("R1", "bios rd in reset", bios_rd_shadow_o, 1'b0);
    rst = 1'b0;
    probe(20'hF0000, 1'b0);
    chk("R1", "rd after reset", rd_int_o, 1'b0);
    chk("R1", "wr after reset", wr_int_o, 1'b0);
    chk("R1", "oor after reset", out_of_range_o, 1'b0);

    // R2 R3 R4 R5 R8 R9 table walk
    for (int k = 0; k < NV; k++) begin
      cfg_write(1'b0, VECS[k].lo, 1'b1);
      cfg_write(1'b1, VECS[k].hi, 1'b1);
      probe(VECS[k].addr, VECS[k].wr);
      chk("R2/R3/R4/R5", "rd_int", rd_int_o, VECS[k].e_rd);
      chk("R4/R5", "wr_int", wr_int_o, VECS[k].e_wr);
      chk("R8", "out_of_range", out_of_range_o, VECS[k].e_oor);
      chk("R9", "acc_int", acc_int_o, VECS[k].e_acc);
      chk("R6", "bios rd", bios_rd_shadow_o, VECS[k].hi[4]);
      chk("R6", "bios wr", bios_wr_shadow_o, VECS[k].hi[5]);
    end

    // R9: invalid access never internal
    @(negedge clk);
    mem_addr = 20'hC4000; mem_valid = 1'b0; mem_write = 1'b0;
    @(negedge clk);
    chk("R9", "acc with valid low", acc_int_o, 1'b0);
    chk("R9", "rd with valid low", rd_int_o, 1'b1);

    // R7: locked writes ignored
    cfg_write(1'b1, 8'h00, 1'b0);
    cfg_write(1'b0, 8'h00, 1'b0);
    chk("R7", "bios rd after locked write", bios_rd_shadow_o, 1'b1);
    probe(20'hC4000, 1'b1);
    chk("R7", "wr_int after locked write", wr_int_o, 1'b1);

    // R6: status changes on the latching edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_unlock = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h20;
    @(posedge clk);
    #1;
    chk("R6", "bios rd right after latch", bios_rd_shadow_o, 1'b0);
    chk("R6", "bios wr right after latch", bios_wr_shadow_o, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0; cfg_unlock = 1'b0;

    // R10: control write and address on the same edge
    cfg_write(1'b1, 8'h30, 1'b1);
    @(negedge clk);
    mem_addr = 20'hC4000; mem_valid = 1'b1; mem_write = 1'b0;
    cfg_we = 1'b1; cfg_unlock = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0; cfg_unlock = 1'b0;
    chk("R10", "rd uses old enable", rd_int_o, 1'b1);
    @(negedge clk);
    chk("R10", "rd uses new enable", rd_int_o, 1'b0);
    mem_valid = 1'b0;

    // R1: reset mid-run clears bytes
    cfg_write(1'b0, 8'hFF, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", "bios rd after reset", bios_rd_shadow_o, 1'b0);
    cfg_write(1'b1, 8'h30, 1'b1);
    probe(20'hC0000, 1'b0);
    chk("R1", "low byte cleared by reset", rd_int_o, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule